// File: doc/BRIEF.md
# PWM Timer Compare Output Generator

This block is a parameterised 16-bit timer/counter with two compare channels, A and B. A 4-bit waveform mode selects three things: how the counter steps, where its TOP value comes from, and what kind of waveform the channels produce. The modes are:

- free-running normal counting;
- clear-on-compare (CTC);
- single-slope fast PWM;
- two dual-slope PWM variants: phase-correct and phase-and-frequency-correct.

Each channel has a 2-bit compare code. The code decides how the channel's pin reacts to a compare match and to BOTTOM (a count of zero). The code and the waveform mode are decoded together, so the same code can give different pin behaviour in different modes.

The block sits beside a register file that supplies the mode fields, the two compare values and a capture value. In some modes the capture value serves as TOP. The block drives:

- two waveform pins, each with an output enable;
- a one-cycle overflow flag;
- one match flag per channel.

Each pin is registered. It takes its new value one clock after the cycle in which the counter shows the value that caused the change. Prescaling, interrupt generation and input capture live elsewhere.

Top module: `pwm_cmp_timer`

## Requirements
- R1: The synchronous active-low reset clears the counter, the count direction, both held compare values and both waveform pins to 0.
- R2: Mode codes select the counting scheme and TOP as follows:
  - 0: normal counting, TOP all ones.
  - 1, 2, 3: phase-correct, TOP 0x00FF, 0x01FF, 0x03FF.
  - 4: CTC, TOP from the channel A compare input.
  - 5, 6, 7: fast PWM, TOP 0x00FF, 0x01FF, 0x03FF.
  - 8: phase-and-frequency-correct, TOP from the capture input.
  - 9: phase-and-frequency-correct, TOP from channel A.
  - 10: phase-correct, TOP from the capture input.
  - 11: phase-correct, TOP from channel A.
  - 12: CTC, TOP from the capture input.
  - 13: reserved.
  - 14: fast PWM, TOP from the capture input.
  - 15: fast PWM, TOP from channel A.
- R3: In fast PWM the counter runs 0..TOP and wraps, giving a period of TOP+1. Code 2'b10 sets the pin at BOTTOM and clears it on a match, so the pin is high for C cycles of each period. Code 2'b11 does the reverse, so the pin is high for TOP+1-C cycles.
- R4: In the dual-slope modes the counter runs up to TOP and then down to 0, giving a period of 2*TOP. Code 2'b10 clears the pin on an up-count match and sets it on a down-count match, so the pin is high for 2*C cycles of each period. Code 2'b11 is inverted, so the pin is high for 2*(TOP-C) cycles.
- R5: In any PWM mode, when the compare value equals TOP and the code's high bit is set, the match is ignored and the pin is set (code 2'b10) or cleared (code 2'b11) at BOTTOM. A compare value of 0 with code 2'b10 holds the pin low.
- R6: Code 2'b01 toggles the pin on a match only for channel A, and only in modes 9, 11, 14 and 15. In every other PWM mode, and always for channel B, code 2'b01 leaves the pin disconnected (output enable low).
- R7: Code 2'b00 keeps the channel's output enable low in every mode.
- R8: In normal and CTC modes, both channels react to a match as follows: 2'b01 toggles, 2'b10 clears, 2'b11 sets. There is no BOTTOM action.
- R9: In PWM modes the compare values in use are held copies. These are reloaded from the inputs at TOP in fast and phase-correct modes, and at BOTTOM in phase-and-frequency-correct modes. In the other modes the inputs take effect at once.
- R10: The overflow flag is high while counting is enabled and the counter is:
  - at TOP in fast PWM;
  - at 0 at the end of a down slope in the dual-slope modes;
  - at all ones in the other modes.
- R11: Each match flag is high in every enabled cycle in which the counter equals that channel's compare value in use.
- R12: While the count enable is low, the counter and both pins hold, and all three flags stay low.
- R13: Mode 13 counts like CTC with TOP from channel A, and keeps both output enables low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_en | input | 1 | Count enable; the counter and pins advance only when high |
| wave_mode | input | 4 | Waveform mode code |
| comp_mode_a | input | 2 | Compare code for channel A |
| comp_mode_b | input | 2 | Compare code for channel B |
| cmp_a_in | input | 16 | Channel A compare value (also a TOP source) |
| cmp_b_in | input | 16 | Channel B compare value |
| cap_top | input | 16 | Capture value used as TOP in some modes |
| wave_a | output | 1 | Channel A waveform pin |
| wave_a_oe | output | 1 | Channel A output enable |
| wave_b | output | 1 | Channel B waveform pin |
| wave_b_oe | output | 1 | Channel B output enable |
| ovf_flag | output | 1 | Overflow flag |
| match_a | output | 1 | Channel A match flag |
| match_b | output | 1 | Channel B match flag |

## Verification
The assertions check, on every cycle:
- that the pins read 0 right after reset;
- that code 2'b00, reserved mode 13 and a channel B toggle request in a PWM mode never drive an output enable;
- that the pins hold after a cycle with the count enable low;
- that no flag rises while the count enable is low.

Duty cycles, periods, the TOP chosen by each mode, the compare-equals-TOP and compare-zero corners, toggling, and when a new compare value takes effect all depend on whole counting periods. Only the bench's scenarios show them, by counting the high cycles of each pin over whole periods after settling.

// File: rtl/pwm_timer_pkg.sv
// Package: shared types for the PWM timer.
// Assumes: imported by every module of the timer; no state of its own.
package pwm_timer_pkg;

    // Counting scheme chosen by the waveform mode.
    typedef enum logic [2:0] {
        KIND_NORMAL,
        KIND_CTC,
        KIND_FAST,
        KIND_PC,
        KIND_PFC,
        KIND_RSVD
    } wave_kind_e;

    // Where the TOP value comes from.
    typedef enum logic [2:0] {
        TSRC_MAX,
        TSRC_8B,
        TSRC_9B,
        TSRC_10B,
        TSRC_CAP,
        TSRC_CMPA
    } top_src_e;

    // Action taken on a pin at the next enabled edge.
    typedef enum logic [1:0] {
        ACT_NONE,
        ACT_SET,
        ACT_CLR,
        ACT_TGL
    } pin_act_e;

    // True for the three PWM counting schemes.
    function automatic logic kind_is_pwm(wave_kind_e k);
        return (k == KIND_FAST) || (k == KIND_PC) || (k == KIND_PFC);
    endfunction

    // True for the up/down counting schemes.
    function automatic logic kind_is_dual(wave_kind_e k);
        return (k == KIND_PC) || (k == KIND_PFC);
    endfunction

endpackage

// File: rtl/pwm_mode_decode.sv
// Module: pwm_mode_decode
// Turns the 4-bit waveform mode into a counting scheme, a TOP source
// and the flag that allows channel A to toggle in a PWM mode.
// Assumes: purely combinational; the TOP value itself is muxed by the caller.
module pwm_mode_decode
    import pwm_timer_pkg::*;
(
    input  logic [3:0]  mode,
    output wave_kind_e  kind,
    output top_src_e    tsrc,
    output logic        tgl_ok
);

    // Decode table for all sixteen mode codes.
    always_comb begin
        kind   = KIND_NORMAL;
        tsrc   = TSRC_MAX;
        tgl_ok = 1'b0;
        case (mode)
            4'd0:  begin kind = KIND_NORMAL; tsrc = TSRC_MAX;  end
            4'd1:  begin kind = KIND_PC;     tsrc = TSRC_8B;   end
            4'd2:  begin kind = KIND_PC;     tsrc = TSRC_9B;   end
            4'd3:  begin kind = KIND_PC;     tsrc = TSRC_10B;  end
            4'd4:  begin kind = KIND_CTC;    tsrc = TSRC_CMPA; end
            4'd5:  begin kind = KIND_FAST;   tsrc = TSRC_8B;   end
            4'd6:  begin kind = KIND_FAST;   tsrc = TSRC_9B;   end
            4'd7:  begin kind = KIND_FAST;   tsrc = TSRC_10B;  end
            4'd8:  begin kind = KIND_PFC;    tsrc = TSRC_CAP;  end
            4'd9:  begin kind = KIND_PFC;    tsrc = TSRC_CMPA; tgl_ok = 1'b1; end
            4'd10: begin kind = KIND_PC;     tsrc = TSRC_CAP;  end
            4'd11: begin kind = KIND_PC;     tsrc = TSRC_CMPA; tgl_ok = 1'b1; end
            4'd12: begin kind = KIND_CTC;    tsrc = TSRC_CAP;  end
            4'd13: begin kind = KIND_RSVD;   tsrc = TSRC_CMPA; end
            4'd14: begin kind = KIND_FAST;   tsrc = TSRC_CAP;  tgl_ok = 1'b1; end
            4'd15: begin kind = KIND_FAST;   tsrc = TSRC_CMPA; tgl_ok = 1'b1; end
            default: begin kind = KIND_NORMAL; tsrc = TSRC_MAX; end
        endcase
    end

endmodule

// File: rtl/pwm_cmp_buffer.sv
// Module: pwm_cmp_buffer
// Holds one channel's compare value. In PWM modes the held copy is used
// and reloaded on the load strobe; otherwise the input passes straight through.
// Assumes: load is only acted on while the count enable is high.
module pwm_cmp_buffer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_en,
    input  logic         pwm,
    input  logic         load,
    input  logic [W-1:0] cmp_in,
    output logic [W-1:0] cmp_eff
);

    logic [W-1:0] held_q;

    // Track the input outside PWM, reload at the update point inside PWM.
    always_ff @(posedge clk) begin
        if (!rst_n)
            held_q <= '0;
        else if (!pwm)
            held_q <= cmp_in;
        else if (cnt_en && load)
            held_q <= cmp_in;
    end

    // Select the compare value in use.
    assign cmp_eff = pwm ? held_q : cmp_in;

endmodule

// File: rtl/pwm_counter.sv
// Module: pwm_counter
// The timer count register and its direction bit. Single-slope schemes
// wrap at TOP (or at all ones when wrap is low); dual-slope schemes turn
// at TOP and at 0.
// Assumes: TOP may change at any time; a count above TOP wraps or turns at once.
module pwm_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_en,
    input  logic         dual,
    input  logic         wrap,
    input  logic [W-1:0] top,
    output logic [W-1:0] cnt,
    output logic         down
);

    localparam logic [W-1:0] ONE = W'(1);

    // Advance the count and direction by one enabled step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            down <= 1'b0;
        end else if (cnt_en) begin
            if (dual) begin
                if (!down) begin
                    if (cnt >= top) begin
                        down <= 1'b1;
                        cnt  <= (top == '0) ? '0 : top - ONE;
                    end else begin
                        cnt <= cnt + ONE;
                    end
                end else if (cnt == '0) begin
                    down <= 1'b0;
                    cnt  <= (top == '0) ? '0 : ONE;
                end else begin
                    cnt <= cnt - ONE;
                end
            end else begin
                down <= 1'b0;
                if (wrap && (cnt >= top))
                    cnt <= '0;
                else
                    cnt <= cnt + ONE;
            end
        end
    end

endmodule

// File: rtl/pwm_pin_ctrl.sv
// Module: pwm_pin_ctrl
// One compare channel's pin logic: decodes the compare code against the
// counting scheme into an output enable and a pin action, and applies the
// action on the next enabled edge.
// Assumes: hit, at_bot and up_slope describe the counter in the current cycle.
module pwm_pin_ctrl
    import pwm_timer_pkg::*;
#(
    parameter bit IS_A = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cnt_en,
    input  wave_kind_e  kind,
    input  logic        tgl_ok,
    input  logic [1:0]  code,
    input  logic        hit,
    input  logic        cmp_is_top,
    input  logic        at_bot,
    input  logic        up_slope,
    output logic        pin,
    output logic        oe
);

    pin_act_e act;
    logic     hi_code;
    logic     inv;

    assign hi_code = code[1];
    assign inv     = code[0];

    // Choose the output enable and the pending pin action.
    always_comb begin
        act = ACT_NONE;
        oe  = 1'b0;
        case (kind)
            KIND_NORMAL, KIND_CTC: begin
                if (code != 2'b00) begin
                    oe = 1'b1;
                    if (hit)
                        act = (code == 2'b01) ? ACT_TGL :
                              (code == 2'b10) ? ACT_CLR : ACT_SET;
                end
            end
            KIND_FAST: begin
                if (code == 2'b01) begin
                    if (IS_A && tgl_ok) begin
                        oe = 1'b1;
                        if (hit) act = ACT_TGL;
                    end
                end else if (hi_code) begin
                    oe = 1'b1;
                    if (hit && !cmp_is_top)
                        act = inv ? ACT_SET : ACT_CLR;
                    else if (at_bot)
                        act = inv ? ACT_CLR : ACT_SET;
                end
            end
            KIND_PC, KIND_PFC: begin
                if (code == 2'b01) begin
                    if (IS_A && tgl_ok) begin
                        oe = 1'b1;
                        if (hit) act = ACT_TGL;
                    end
                end else if (hi_code) begin
                    oe = 1'b1;
                    if (hit && !cmp_is_top)
                        act = (up_slope ^ inv) ? ACT_CLR : ACT_SET;
                    else if (at_bot && cmp_is_top)
                        act = inv ? ACT_CLR : ACT_SET;
                end
            end
            default: begin
                act = ACT_NONE;
                oe  = 1'b0;
            end
        endcase
    end

    // Apply the pending action on an enabled edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pin <= 1'b0;
        else if (cnt_en) begin
            case (act)
                ACT_SET: pin <= 1'b1;
                ACT_CLR: pin <= 1'b0;
                ACT_TGL: pin <= ~pin;
                default: pin <= pin;
            endcase
        end
    end

endmodule

// File: rtl/pwm_cmp_timer.sv
// Module: pwm_cmp_timer (top)
// A timer/counter with two compare channels and mode-dependent pin
// actions. Ties together the mode decoder, the counter, one compare buffer
// per channel and one pin controller per channel.
// Assumes: all inputs are synchronous to clk; W is at least 10 so that
// the fixed TOP values fit.
module pwm_cmp_timer
    import pwm_timer_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_en,
    input  logic [3:0]   wave_mode,
    input  logic [1:0]   comp_mode_a,
    input  logic [1:0]   comp_mode_b,
    input  logic [W-1:0] cmp_a_in,
    input  logic [W-1:0] cmp_b_in,
    input  logic [W-1:0] cap_top,
    output logic         wave_a,
    output logic         wave_a_oe,
    output logic         wave_b,
    output logic         wave_b_oe,
    output logic         ovf_flag,
    output logic         match_a,
    output logic         match_b
);

    localparam int           NCH     = 2;
    localparam logic [W-1:0] TOP_8B  = W'(255);
    localparam logic [W-1:0] TOP_9B  = W'(511);
    localparam logic [W-1:0] TOP_10B = W'(1023);

    wave_kind_e   kind;
    top_src_e     tsrc;
    logic         tgl_ok;
    logic         is_pwm;
    logic         is_dual;
    logic [W-1:0] top;
    logic [W-1:0] cnt;
    logic         down;
    logic         at_top;
    logic         at_bot;
    logic         up_slope;
    logic         buf_load;

    logic [W-1:0] cmp_in_arr  [NCH];
    logic [W-1:0] cmp_eff_arr [NCH];
    logic [1:0]   code_arr    [NCH];
    logic         hit_arr     [NCH];
    logic         pin_arr     [NCH];
    logic         oe_arr      [NCH];

    assign cmp_in_arr[0] = cmp_a_in;
    assign cmp_in_arr[1] = cmp_b_in;
    assign code_arr[0]   = comp_mode_a;
    assign code_arr[1]   = comp_mode_b;

    pwm_mode_decode u_dec (
        .mode   (wave_mode),
        .kind   (kind),
        .tsrc   (tsrc),
        .tgl_ok (tgl_ok)
    );

    assign is_pwm  = kind_is_pwm(kind);
    assign is_dual = kind_is_dual(kind);

    // Select the TOP value for the current mode.
    always_comb begin
        case (tsrc)
            TSRC_8B:   top = TOP_8B;
            TSRC_9B:   top = TOP_9B;
            TSRC_10B:  top = TOP_10B;
            TSRC_CAP:  top = cap_top;
            TSRC_CMPA: top = cmp_eff_arr[0];
            default:   top = '1;
        endcase
    end

    pwm_counter #(.W(W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt_en (cnt_en),
        .dual   (is_dual),
        .wrap   (kind != KIND_NORMAL),
        .top    (top),
        .cnt    (cnt),
        .down   (down)
    );

    assign at_top   = (cnt == top);
    assign at_bot   = (cnt == '0);
    assign up_slope = !down || at_bot;
    assign buf_load = (kind == KIND_PFC) ? at_bot : at_top;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        pwm_cmp_buffer #(.W(W)) u_buf (
            .clk     (clk),
            .rst_n   (rst_n),
            .cnt_en  (cnt_en),
            .pwm     (is_pwm),
            .load    (buf_load),
            .cmp_in  (cmp_in_arr[ch]),
            .cmp_eff (cmp_eff_arr[ch])
        );

        assign hit_arr[ch] = (cnt == cmp_eff_arr[ch]);

        pwm_pin_ctrl #(.IS_A(ch == 0)) u_pin (
            .clk        (clk),
            .rst_n      (rst_n),
            .cnt_en     (cnt_en),
            .kind       (kind),
            .tgl_ok     (tgl_ok),
            .code       (code_arr[ch]),
            .hit        (hit_arr[ch]),
            .cmp_is_top (cmp_eff_arr[ch] == top),
            .at_bot     (at_bot),
            .up_slope   (up_slope),
            .pin        (pin_arr[ch]),
            .oe         (oe_arr[ch])
        );
    end

    // Overflow point depends on the counting scheme.
    always_comb begin
        if (!cnt_en)
            ovf_flag = 1'b0;
        else if (kind == KIND_FAST)
            ovf_flag = at_top;
        else if (is_dual)
            ovf_flag = at_bot && down;
        else
            ovf_flag = (cnt == '1);
    end

    assign match_a   = cnt_en && hit_arr[0];
    assign match_b   = cnt_en && hit_arr[1];
    assign wave_a    = pin_arr[0];
    assign wave_b    = pin_arr[1];
    assign wave_a_oe = oe_arr[0];
    assign wave_b_oe = oe_arr[1];

endmodule

// File: rtl/pwm_cmp_timer_chk.sv
// Module: pwm_cmp_timer_chk
// Cycle-by-cycle properties of the timer's ports, bound to every instance
// of pwm_cmp_timer.
// Assumes: port names match the top module so that the bind can use .*.
module pwm_cmp_timer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cnt_en,
    input logic [3:0] wave_mode,
    input logic [1:0] comp_mode_a,
    input logic [1:0] comp_mode_b,
    input logic       wave_a,
    input logic       wave_a_oe,
    input logic       wave_b,
    input logic       wave_b_oe,
    input logic       ovf_flag,
    input logic       match_a,
    input logic       match_b
);

    logic past_valid;

    // Marks that at least one edge has passed.
    always_ff @(posedge clk) past_valid <= 1'b1;

    a_r1_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid && !$past(rst_n)) |-> (!wave_a && !wave_b));

    a_r7_code0_off: assert property (@(posedge clk) disable iff (!rst_n)
        ((comp_mode_a == 2'b00) |-> !wave_a_oe) and
        ((comp_mode_b == 2'b00) |-> !wave_b_oe));

    a_r6_b_no_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        ((comp_mode_b == 2'b01) && (wave_mode != 4'd0) && (wave_mode != 4'd4) &&
         (wave_mode != 4'd12) && (wave_mode != 4'd13)) |-> !wave_b_oe);

    a_r13_rsvd_off: assert property (@(posedge clk) disable iff (!rst_n)
        (wave_mode == 4'd13) |-> (!wave_a_oe && !wave_b_oe));

    a_r12_hold_pins: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(cnt_en)) |-> ($stable(wave_a) && $stable(wave_b)));

    a_r12_flags_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en |-> !(ovf_flag || match_a || match_b));

endmodule

bind pwm_cmp_timer pwm_cmp_timer_chk chk (.*);

// File: tb/pwm_cmp_timer_test.sv
`timescale 1ns/1ps
module pwm_cmp_timer_test;

    typedef struct packed {
        logic [3:0]  mode;
        logic [1:0]  ca;
        logic [1:0]  cb;
        logic [15:0] a;
        logic [15:0] b;
        logic [15:0] cap;
        logic [15:0] period;
        logic [15:0] exp_a;
        logic [15:0] exp_b;
        logic        oe_a;
        logic        oe_b;
    } vec_t;

    // exp_a / exp_b: high cycles of each pin over two whole periods.
    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{4'd14, 2'd2, 2'd3, 16'd3,   16'd2,   16'd9, 16'd10,  16'd6,   16'd16,  1'b1, 1'b1}, // R3 R2
        '{4'd14, 2'd2, 2'd2, 16'd9,   16'd0,   16'd9, 16'd10,  16'd20,  16'd0,   1'b1, 1'b1}, // R5
        '{4'd15, 2'd1, 2'd1, 16'd11,  16'd0,   16'd0, 16'd12,  16'd12,  16'd0,   1'b1, 1'b0}, // R6
        '{4'd10, 2'd2, 2'd3, 16'd3,   16'd5,   16'd8, 16'd16,  16'd12,  16'd12,  1'b1, 1'b1}, // R4
        '{4'd10, 2'd2, 2'd2, 16'd8,   16'd0,   16'd8, 16'd16,  16'd32,  16'd0,   1'b1, 1'b1}, // R5
        '{4'd8,  2'd3, 2'd2, 16'd2,   16'd5,   16'd6, 16'd12,  16'd16,  16'd20,  1'b1, 1'b1}, // R4
        '{4'd11, 2'd1, 2'd2, 16'd7,   16'd3,   16'd0, 16'd14,  16'd14,  16'd12,  1'b1, 1'b1}, // R6 R4
        '{4'd5,  2'd2, 2'd3, 16'd100, 16'd200, 16'd0, 16'd256, 16'd200, 16'd112, 1'b1, 1'b1}, // R2 R3
        '{4'd1,  2'd2, 2'd1, 16'd64,  16'd0,   16'd0, 16'd510, 16'd256, 16'd0,   1'b1, 1'b0}, // R2 R6
        '{4'd4,  2'd1, 2'd1, 16'd5,   16'd2,   16'd0, 16'd6,   16'd6,   16'd6,   1'b1, 1'b1}, // R8
        '{4'd12, 2'd2, 2'd3, 16'd3,   16'd4,   16'd7, 16'd8,   16'd0,   16'd16,  1'b1, 1'b1}, // R8
        '{4'd9,  2'd1, 2'd3, 16'd5,   16'd1,   16'd0, 16'd10,  16'd10,  16'd16,  1'b1, 1'b1}  // R6 R4 R9
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_en = 1'b0;
    logic [3:0]  wave_mode = 4'd0;
    logic [1:0]  comp_mode_a = 2'd0;
    logic [1:0]  comp_mode_b = 2'd0;
    logic [15:0] cmp_a_in = 16'd0;
    logic [15:0] cmp_b_in = 16'd0;
    logic [15:0] cap_top = 16'd0;
    logic        wave_a, wave_a_oe, wave_b, wave_b_oe, ovf_flag, match_a, match_b;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pwm_cmp_timer uut (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wave_mode(wave_mode),
        .comp_mode_a(comp_mode_a), .comp_mode_b(comp_mode_b),
        .cmp_a_in(cmp_a_in), .cmp_b_in(cmp_b_in), .cap_top(cap_top),
        .wave_a(wave_a), .wave_a_oe(wave_a_oe), .wave_b(wave_b), .wave_b_oe(wave_b_oe),
        .ovf_flag(ovf_flag), .match_a(match_a), .match_b(match_b)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic setup(input logic [3:0] m, input logic [1:0] ca, input logic [1:0] cb,
                         input logic [15:0] a, input logic [15:0] b, input logic [15:0] cp);
        @(negedge clk);
        rst_n = 1'b0;
        wave_mode = m; comp_mode_a = ca; comp_mode_b = cb;
        cmp_a_in = a; cmp_b_in = b; cap_top = cp;
        cnt_en = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int ha, hb, n, chg;
        logic a0, b0;

        // R1: reset state with counting disabled
        cnt_en = 1'b0; wave_mode = 4'd14; comp_mode_a = 2'd3; comp_mode_b = 2'd3;
        cap_top = 16'd9; cmp_a_in = 16'd0; cmp_b_in = 16'd0;
        repeat (3) @(negedge clk);
        check("R1 wave_a after reset", wave_a, 0);
        check("R1 wave_b after reset", wave_b, 0);
        check("R1 ovf_flag in reset", ovf_flag, 0);
        check("R1 match_a in reset", match_a, 0);

        // Vector table: duty over two whole periods after settling
        for (int v = 0; v < NV; v++) begin
            setup(VECS[v].mode, VECS[v].ca, VECS[v].cb, VECS[v].a, VECS[v].b, VECS[v].cap);
            repeat (3 * int'(VECS[v].period)) @(negedge clk);
            ha = 0; hb = 0;
            for (int i = 0; i < 2 * int'(VECS[v].period); i++) begin
                ha += int'(wave_a);
                hb += int'(wave_b);
                @(negedge clk);
            end
            check($sformatf("vector %0d duty A (R2..R8 table)", v), ha, int'(VECS[v].exp_a));
            check($sformatf("vector %0d duty B (R2..R8 table)", v), hb, int'(VECS[v].exp_b));
            check($sformatf("vector %0d oe A", v), wave_a_oe, int'(VECS[v].oe_a));
            check($sformatf("vector %0d oe B", v), wave_b_oe, int'(VECS[v].oe_b));
        end

        // R7: code 00 disconnects in PWM and non-PWM modes
        setup(4'd14, 2'd0, 2'd0, 16'd3, 16'd3, 16'd9);
        @(negedge clk);
        check("R7 oe A code 00 fast", wave_a_oe, 0);
        check("R7 oe B code 00 fast", wave_b_oe, 0);
        wave_mode = 4'd0; @(negedge clk);
        check("R7 oe A code 00 normal", wave_a_oe, 0);

        // R6: toggle refused outside the allowed modes
        wave_mode = 4'd7; comp_mode_a = 2'd1; @(negedge clk);
        check("R6 toggle A refused mode 7", wave_a_oe, 0);
        wave_mode = 4'd10; @(negedge clk);
        check("R6 toggle A refused mode 10", wave_a_oe, 0);
        wave_mode = 4'd9; comp_mode_b = 2'd1; @(negedge clk);
        check("R6 toggle B refused mode 9", wave_b_oe, 0);
        check("R6 toggle A allowed mode 9", wave_a_oe, 1);

        // R13: reserved mode keeps both pins disconnected
        wave_mode = 4'd13; comp_mode_a = 2'd2; comp_mode_b = 2'd3; @(negedge clk);
        check("R13 oe A reserved", wave_a_oe, 0);
        check("R13 oe B reserved", wave_b_oe, 0);

        // R10 R11: flag rates in fast PWM (period 10)
        setup(4'd14, 2'd2, 2'd3, 16'd3, 16'd2, 16'd9);
        repeat (30) @(negedge clk);
        ha = 0; hb = 0;
        for (int i = 0; i < 20; i++) begin
            ha += int'(ovf_flag);
            hb += int'(match_a);
            @(negedge clk);
        end
        check("R10 overflow pulses fast", ha, 2);
        check("R11 match A pulses", hb, 2);

        // R12: disabling the count freezes pins and silences flags
        cnt_en = 1'b0;
        a0 = wave_a; b0 = wave_b; chg = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (wave_a != a0 || wave_b != b0) chg++;
            chg += int'(ovf_flag) + int'(match_a) + int'(match_b);
        end
        check("R12 frozen outputs and idle flags", chg, 0);
        cnt_en = 1'b1;

        // R9: new compare value waits for TOP in fast PWM
        repeat (25) @(negedge clk);
        while (!ovf_flag) @(negedge clk);
        @(negedge clk);
        cmp_a_in = 16'd6;
        n = 0;
        for (int i = 0; i < 10; i++) begin
            n += int'(wave_a);
            @(negedge clk);
        end
        check("R9 old compare kept until TOP", n, 3);
        n = 0;
        for (int i = 0; i < 10; i++) begin
            n += int'(wave_a);
            @(negedge clk);
        end
        check("R9 new compare after TOP", n, 6);

        // R10: overflow in dual slope (period 16)
        setup(4'd10, 2'd2, 2'd2, 16'd3, 16'd3, 16'd8);
        repeat (48) @(negedge clk);
        ha = 0;
        for (int i = 0; i < 32; i++) begin
            ha += int'(ovf_flag);
            @(negedge clk);
        end
        check("R10 overflow pulses dual slope", ha, 2);

        finish_run();
    end

endmodule